// File: doc/BRIEF.md
# Block Transfer DMA Engine

The engine copies bytes between a 16-bit host address space and an expansion RAM with a 24-bit address space. Software programs a small byte-wide register file with a host start address, an expansion start address, a byte count, per-side address-hold flags and a command byte. The transfer then starts either at once or on a later trigger pulse. Four modes are offered: host to expansion, expansion to host, an in-place swap of the two bytes, and a compare that stops at the first byte that differs.

Each step moves one byte. Host accesses wait for a bus grant, and the expansion RAM is accessed directly. A `size_sel` input fixes the installed expansion size, and the driven expansion address is masked to that size. When the transfer ends, the engine writes the final pointers and the remaining count back into the register file unless autoload is set. It then posts a done flag and clears the execute bit.

Top module: `xfer_dma`

## Requirements
- R1: After reset, location 0 reads 0x40, plus 0x10 when `size_sel` is not 0. Locations 1 to 8 read 0, location 10 reads 0x3F, and locations 9 and 11 to 15 read 0xFF. Writes to location 0 have no effect. The host start address is at locations 2 (low byte) and 3 (high byte). The expansion start address is at locations 4, 5 and 6, low byte first. The count is at locations 7 (low) and 8 (high). Location 10 bit 7 is the host hold flag and bit 6 is the expansion hold flag, and its bits 5:0 read as 1.
- R2: Writing location 1 with bits 7 and 4 both set starts a transfer on that edge. Writing it with bit 7 set and bit 4 clear arms the engine, and a later `trigger` pulse starts the transfer. A `trigger` pulse while command bit 7 is clear has no effect.
- R3: `size_sel` gives the expansion size: 0 selects 128 KB, 1 selects 256 KB, and 2 or 3 select 512 KB. `x_addr` never has a bit set above that size. The internal expansion pointer keeps all 24 bits, and all 24 bits are written back.
- R4: When a hold flag is set, that side's address stays fixed. When it is clear, the address steps by one per byte, wrapping modulo 2^16 on the host side and 2^24 on the expansion side.
- R5: Command bits 1:0 select the mode: 0 copies host to expansion, 1 copies expansion to host, 2 swaps, and 3 compares. Compare mode writes neither memory.
- R6: In compare mode, the first byte that differs sets status bit 5 and ends the transfer. The written-back pointers address that byte, and the written-back count includes it.
- R7: A programmed count of 0 transfers 65536 bytes.
- R8: On the edge where `busy` falls, status bit 6 becomes set and command bit 7 becomes clear.
- R9: When command bit 5 (autoload) is clear, the final host pointer, expansion pointer and remaining count are written back, and a full run leaves a count of 0. When autoload is set, those registers keep the programmed values.
- R10: A read strobe on location 0 clears status bits 6 and 5 after returning them.
- R11: A host access is held, with a stable address, until `h_gnt` is high. A swap step performs, in order, a host read, an expansion read, a host write and an expansion write.
- R12: `busy` is high from the launch edge until done is posted. While it is high, `trigger` and register writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| size_sel | input | 2 | Installed expansion size select |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (clears status on location 0) |
| reg_addr | input | 4 | Register location |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| trigger | input | 1 | Deferred start pulse |
| busy | output | 1 | Transfer in progress |
| h_addr | output | 16 | Host address |
| h_rd | output | 1 | Host read request, held until granted |
| h_wr | output | 1 | Host write request, held until granted |
| h_wdata | output | 8 | Host write data |
| h_rdata | input | 8 | Host read data, valid the cycle after a granted read |
| h_gnt | input | 1 | Host bus grant |
| x_addr | output | 24 | Expansion address, masked to size |
| x_re | output | 1 | Expansion read, data valid the next cycle |
| x_we | output | 1 | Expansion write |
| x_wdata | output | 8 | Expansion write data |
| x_rdata | input | 8 | Expansion read data |

## Verification
The bench runs a 65536-byte count through a compare that misses at byte 100. A design that read a zero count as zero would end at once or write back a count that underflows. A mismatch in the middle of a compare must leave the pointers on the bad byte. An off-by-one there shows up as a shifted address or a count one too small. The bench also starts expansion pointers just below a size boundary: a missing mask drives `x_addr` above the RAM, and masking the written-back value loses the upper bits. Deferred starts, trigger pulses while disarmed, and register writes during a run are used to catch a design that relaunches or lets a run corrupt the programmed state.

// File: rtl/xfer_dma.sv
module xfer_dma (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  size_sel,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [3:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        trigger,
  output logic        busy,
  output logic [15:0] h_addr,
  output logic        h_rd,
  output logic        h_wr,
  output logic [7:0]  h_wdata,
  input  logic [7:0]  h_rdata,
  input  logic        h_gnt,
  output logic [23:0] x_addr,
  output logic        x_re,
  output logic        x_we,
  output logic [7:0]  x_wdata,
  input  logic [7:0]  x_rdata
);

  typedef enum logic [3:0] {
    S_IDLE, S_HRD, S_HLAT, S_XRD, S_XLAT, S_HWR, S_XWR, S_CMP, S_ADV, S_FIN
  } state_t;

  state_t      st;
  logic [15:0] hbase, lenr, hptr;
  logic [23:0] xbase, xptr, xmask;
  logic [16:0] left;
  logic [7:0]  cmd, hbuf, xbuf;
  logic        hold_h, hold_x, done_f, miss_f;
  logic [1:0]  mode_r, fmode;
  logic        hh_r, hx_r, al_r;
  logic        idle, wr_ok, go_cmd, go_trg, launch;

  assign xmask  = (size_sel == 2'd0) ? 24'h01FFFF :
                  (size_sel == 2'd1) ? 24'h03FFFF : 24'h07FFFF;
  assign idle   = (st == S_IDLE);
  assign wr_ok  = reg_we && idle;
  assign go_cmd = wr_ok && reg_addr == 4'd1 && reg_wdata[7] && reg_wdata[4];
  assign go_trg = trigger && idle && cmd[7] && !cmd[4] && !go_cmd;
  assign launch = go_cmd || go_trg;
  assign fmode  = go_cmd ? reg_wdata[1:0] : cmd[1:0];

  assign busy    = !idle;
  assign h_addr  = hptr;
  assign h_rd    = (st == S_HRD);
  assign h_wr    = (st == S_HWR);
  assign h_wdata = xbuf;
  assign x_addr  = xptr & xmask;
  assign x_re    = (st == S_XRD);
  assign x_we    = (st == S_XWR);
  assign x_wdata = hbuf;

  always_comb begin
    case (reg_addr)
      4'd0:    reg_rdata = {1'b0, done_f, miss_f, size_sel != 2'd0, 4'h0};
      4'd1:    reg_rdata = cmd;
      4'd2:    reg_rdata = hbase[7:0];
      4'd3:    reg_rdata = hbase[15:8];
      4'd4:    reg_rdata = xbase[7:0];
      4'd5:    reg_rdata = xbase[15:8];
      4'd6:    reg_rdata = xbase[23:16];
      4'd7:    reg_rdata = lenr[7:0];
      4'd8:    reg_rdata = lenr[15:8];
      4'd10:   reg_rdata = {hold_h, hold_x, 6'h3F};
      default: reg_rdata = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      hbase  <= '0;
      xbase  <= '0;
      lenr   <= '0;
      cmd    <= '0;
      hold_h <= 1'b0;
      hold_x <= 1'b0;
      done_f <= 1'b1;
      miss_f <= 1'b0;
      hptr   <= '0;
      xptr   <= '0;
      left   <= '0;
      hbuf   <= '0;
      xbuf   <= '0;
      mode_r <= '0;
      hh_r   <= 1'b0;
      hx_r   <= 1'b0;
      al_r   <= 1'b0;
    end else begin
      if (reg_re && reg_addr == 4'd0) begin
        done_f <= 1'b0;
        miss_f <= 1'b0;
      end
      if (wr_ok) begin
        case (reg_addr)
          4'd1:  cmd          <= reg_wdata;
          4'd2:  hbase[7:0]   <= reg_wdata;
          4'd3:  hbase[15:8]  <= reg_wdata;
          4'd4:  xbase[7:0]   <= reg_wdata;
          4'd5:  xbase[15:8]  <= reg_wdata;
          4'd6:  xbase[23:16] <= reg_wdata;
          4'd7:  lenr[7:0]    <= reg_wdata;
          4'd8:  lenr[15:8]   <= reg_wdata;
          4'd10: begin
            hold_h <= reg_wdata[7];
            hold_x <= reg_wdata[6];
          end
          default: ;
        endcase
      end
      if (launch) begin
        hptr   <= hbase;
        xptr   <= xbase;
        left   <= (lenr == 16'd0) ? 17'h10000 : {1'b0, lenr};
        mode_r <= fmode;
        al_r   <= go_cmd ? reg_wdata[5] : cmd[5];
        hh_r   <= hold_h;
        hx_r   <= hold_x;
        st     <= (fmode == 2'd1) ? S_XRD : S_HRD;
      end
      case (st)
        S_HRD:  if (h_gnt) st <= S_HLAT;
        S_HLAT: begin
          hbuf <= h_rdata;
          st   <= (mode_r == 2'd0) ? S_XWR : S_XRD;
        end
        S_XRD:  st <= S_XLAT;
        S_XLAT: begin
          xbuf <= x_rdata;
          st   <= (mode_r == 2'd3) ? S_CMP : S_HWR;
        end
        S_HWR:  if (h_gnt) st <= (mode_r == 2'd2) ? S_XWR : S_ADV;
        S_XWR:  st <= S_ADV;
        S_CMP: begin
          if (hbuf != xbuf) begin
            miss_f <= 1'b1;
            st     <= S_FIN;
          end else begin
            st <= S_ADV;
          end
        end
        S_ADV: begin
          hptr <= hptr + {15'd0, !hh_r};
          xptr <= xptr + {23'd0, !hx_r};
          left <= left - 17'd1;
          if (left == 17'd1)        st <= S_FIN;
          else if (mode_r == 2'd1)  st <= S_XRD;
          else                      st <= S_HRD;
        end
        S_FIN: begin
          if (!al_r) begin
            hbase <= hptr;
            xbase <= xptr;
            lenr  <= left[15:0];
          end
          done_f <= 1'b1;
          cmd[7] <= 1'b0;
          st     <= S_IDLE;
        end
        default: ;
      endcase
    end
  end

  AST_HOST_EXCL:  assert property (@(posedge clk) disable iff (!rst_n) !(h_rd && h_wr)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !(h_rd || h_wr || x_re || x_we)); // R12
  AST_DONE_POST:  assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> (done_f && !cmd[7])); // R8
  AST_HOST_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy) && hh_r) |-> $stable(hptr)); // R4
  AST_EXP_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy) && hx_r) |-> $stable(xptr)); // R4
  AST_CMP_NOWR:   assert property (@(posedge clk) disable iff (!rst_n) (busy && mode_r == 2'd3) |-> !(h_wr || x_we)); // R5
  AST_WAIT_GNT:   assert property (@(posedge clk) disable iff (!rst_n) (h_rd && !h_gnt) |=> (h_rd && $stable(h_addr))); // R11

endmodule

// File: tb/xfer_dma_test.sv
module xfer_dma_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [1:0]  size_sel = 2'd0;
  logic        reg_we = 1'b0, reg_re = 1'b0, trigger = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [7:0]  reg_wdata = 8'd0, reg_rdata;
  logic        busy, h_rd, h_wr, h_gnt = 1'b1, x_re, x_we;
  logic [15:0] h_addr;
  logic [7:0]  h_wdata, h_rdata = 8'd0, x_wdata, x_rdata = 8'd0;
  logic [23:0] x_addr;

  xfer_dma uut (.*);

  logic [7:0] hmem [1024];
  logic [7:0] xmem [1024];
  logic [7:0] sh_h [1024];
  logic [7:0] sh_x [1024];
  int checks = 0, fails = 0, gcnt = 0, n_wait = 0;
  logic addr_bad = 1'b0;

  function automatic logic [23:0] mask_of(input logic [1:0] s);
    return (s == 2'd0) ? 24'h01FFFF : (s == 2'd1) ? 24'h03FFFF : 24'h07FFFF;
  endfunction

  always @(posedge clk) begin
    if (h_rd && h_gnt) h_rdata <= hmem[h_addr[9:0]];
    if (h_wr && h_gnt) hmem[h_addr[9:0]] <= h_wdata;
    if (x_re) x_rdata <= xmem[x_addr[9:0]];
    if (x_we) xmem[x_addr[9:0]] <= x_wdata;
    if ((x_re || x_we) && (x_addr & ~mask_of(size_sel)) != 24'd0) addr_bad <= 1'b1;
    if (h_rd && !h_gnt) n_wait <= n_wait + 1;
  end
  always @(negedge clk) begin
    gcnt  <= gcnt + 1;
    h_gnt <= (gcnt % 4) != 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic clr, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_re = clr; #1 d = reg_rdata;
    @(negedge clk); reg_re = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trigger = 1'b1;
    @(negedge clk); trigger = 1'b0;
  endtask

  function automatic logic [9:0] hidx(input logic [15:0] b, input int j, input logic hh);
    logic [15:0] a;
    a = b + (hh ? 16'd0 : 16'(j));
    return a[9:0];
  endfunction

  function automatic logic [9:0] xidx(input logic [23:0] b, input int j, input logic hx, input logic [1:0] s);
    logic [23:0] a;
    a = (b + (hx ? 24'd0 : 24'(j))) & mask_of(s);
    return a[9:0];
  endfunction

  localparam int NV = 12;
  // {mode, hold_h, hold_x, autoload, size, pad, host base, exp base, count, mismatch offset}
  localparam logic [79:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0100, 24'h000200, 16'd8,  16'hFFFF}, // R5 R9
    {2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0340, 24'h010010, 16'd5,  16'hFFFF}, // R5
    {2'd2, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 16'h0180, 24'h020300, 16'd6,  16'hFFFF}, // R5 R11
    {2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0050, 24'h000400, 16'd4,  16'hFFFF}, // R4
    {2'd1, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 16'h0060, 24'h000500, 16'd4,  16'hFFFF}, // R4
    {2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0200, 24'h000600, 16'd10, 16'hFFFF}, // R5
    {2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0210, 24'h000700, 16'd10, 16'd3},    // R6
    {2'd0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 16'h0220, 24'h000800, 16'd3,  16'hFFFF}, // R9
    {2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0230, 24'h0FFFFE, 16'd4,  16'hFFFF}, // R3
    {2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 16'hFFFE, 24'h000900, 16'd4,  16'hFFFF}, // R4
    {2'd2, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 16'h0240, 24'h07FFFF, 16'd2,  16'hFFFF}, // R3
    {2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0300, 24'h000A00, 16'd0,  16'd100}   // R7
  };
  string vtag [NV] = '{"R5 R9 h2x", "R5 x2h", "R5 R11 swap", "R4 host hold", "R4 exp hold",
                       "R5 cmp equal", "R6 cmp miss", "R9 autoload", "R3 mask 128K",
                       "R4 host wrap", "R3 mask 256K", "R7 zero count"};

  task automatic ref_run(input logic [1:0] m, input logic hh, input logic hx, input logic [1:0] s,
                         input logic [15:0] hb, input logic [23:0] xb, input logic [15:0] ln,
                         output logic [15:0] eh, output logic [23:0] ex, output logic [15:0] el,
                         output logic emiss);
    int n;
    logic [7:0] t;
    logic [23:0] xa;
    logic [9:0] hi, xi;
    n = (ln == 16'd0) ? 65536 : int'(ln);
    eh = hb; ex = xb; emiss = 1'b0;
    while (n > 0) begin
      hi = eh[9:0];
      xa = ex & mask_of(s);
      xi = xa[9:0];
      if (m == 2'd0) sh_x[xi] = sh_h[hi];
      else if (m == 2'd1) sh_h[hi] = sh_x[xi];
      else if (m == 2'd2) begin t = sh_h[hi]; sh_h[hi] = sh_x[xi]; sh_x[xi] = t; end
      else if (sh_h[hi] != sh_x[xi]) begin emiss = 1'b1; break; end
      n--;
      eh = eh + (hh ? 16'd0 : 16'd1);
      ex = ex + (hx ? 24'd0 : 24'd1);
    end
    el = n[15:0];
  endtask

  task automatic wait_idle(input string tag, output logic [7:0] stat);
    int w;
    w = 0;
    while (busy && w < 20000) begin @(negedge clk); w++; end
    if (busy) begin
      checks++; fails++;
      $display("FAIL %s: watchdog, busy stuck actual 1 expected 0", tag);
    end
    reg_addr = 4'd0; #1 stat = reg_rdata;
  endtask

  task automatic do_xfer(input logic [79:0] v, input int k, input logic deferred, input string tag);
    logic [1:0] m, s; logic hh, hx, al;
    logic [15:0] hb, ln, df, eh, el; logic [23:0] xb, ex; logic emiss;
    logic [7:0] st, d0, d1, d2; int n, lim, bad_h, bad_x;
    {m, hh, hx, al, s} = v[79:73];
    hb = v[71:56]; xb = v[55:32]; ln = v[31:16]; df = v[15:0];
    size_sel = s;
    for (int i = 0; i < 1024; i++) begin
      hmem[i] = 8'(i * 7 + k * 3);
      xmem[i] = 8'(i * 13 + k * 5 + 1);
    end
    if (m == 2'd3) begin
      n = (ln == 16'd0) ? 65536 : int'(ln);
      lim = (df != 16'hFFFF) ? int'(df) : n;
      for (int j = 0; j < lim; j++) xmem[xidx(xb, j, hx, s)] = hmem[hidx(hb, j, hh)];
      if (df != 16'hFFFF) xmem[xidx(xb, int'(df), hx, s)] = ~hmem[hidx(hb, int'(df), hh)];
    end
    for (int i = 0; i < 1024; i++) begin sh_h[i] = hmem[i]; sh_x[i] = xmem[i]; end
    ref_run(m, hh, hx, s, hb, xb, ln, eh, ex, el, emiss);
    if (al) begin eh = hb; ex = xb; el = ln; end
    wr(4'd2, hb[7:0]);  wr(4'd3, hb[15:8]);
    wr(4'd4, xb[7:0]);  wr(4'd5, xb[15:8]); wr(4'd6, xb[23:16]);
    wr(4'd7, ln[7:0]);  wr(4'd8, ln[15:8]);
    wr(4'd10, {hh, hx, 6'd0});
    if (!deferred) begin
      wr(4'd1, {1'b1, 1'b0, al, 1'b1, 2'b00, m});
    end else begin
      wr(4'd1, {1'b1, 1'b0, al, 1'b0, 2'b00, m});
      chk({tag, " R2 armed, not started"}, 32'(busy), 32'd0);
      pulse_trig();
      chk({tag, " R2 trigger starts"}, 32'(busy), 32'd1);
      wr(4'd10, 8'hC0);
      pulse_trig();
    end
    wait_idle(tag, st);
    chk({tag, " R8 done bit on busy fall"}, 32'(st[6]), 32'd1);
    chk({tag, " R6 mismatch bit"}, 32'(st[5]), 32'(emiss));
    bad_h = 0; bad_x = 0;
    for (int i = 0; i < 1024; i++) begin
      if (hmem[i] !== sh_h[i]) bad_h++;
      if (xmem[i] !== sh_x[i]) bad_x++;
    end
    chk({tag, " host memory"}, 32'(bad_h), 32'd0);
    chk({tag, " expansion memory"}, 32'(bad_x), 32'd0);
    rd(4'd2, 1'b0, d0); rd(4'd3, 1'b0, d1);
    chk({tag, " R9 host pointer"}, {16'd0, d1, d0}, {16'd0, eh});
    rd(4'd4, 1'b0, d0); rd(4'd5, 1'b0, d1); rd(4'd6, 1'b0, d2);
    chk({tag, " R9 expansion pointer"}, {8'd0, d2, d1, d0}, {8'd0, ex});
    rd(4'd7, 1'b0, d0); rd(4'd8, 1'b0, d1);
    chk({tag, " R9 count"}, {16'd0, d1, d0}, {16'd0, el});
    rd(4'd1, 1'b0, d0);
    chk({tag, " R8 execute bit cleared"}, 32'(d0[7]), 32'd0);
    if (deferred) begin
      rd(4'd10, 1'b0, d0);
      chk({tag, " R12 write while busy ignored"}, 32'(d0), {24'd0, hh, hx, 6'h3F});
    end
    rd(4'd0, 1'b1, d0);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 190000) begin @(posedge clk); wd++; end
    checks++; fails++;
    $display("FAIL global watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 busy low after reset", 32'(busy), 32'd0);
    rd(4'd0, 1'b0, d);  chk("R1 status reset", 32'(d), 32'h40);
    for (int a = 1; a <= 8; a++) begin
      rd(4'(a), 1'b0, d); chk($sformatf("R1 loc %0d reset", a), 32'(d), 32'd0);
    end
    rd(4'd9, 1'b0, d);  chk("R1 loc 9", 32'(d), 32'hFF);
    rd(4'd10, 1'b0, d); chk("R1 loc 10 reset", 32'(d), 32'h3F);
    rd(4'd13, 1'b0, d); chk("R1 loc 13", 32'(d), 32'hFF);
    size_sel = 2'd1;
    rd(4'd0, 1'b0, d);  chk("R1 R3 size bit", 32'(d), 32'h50);
    size_sel = 2'd0;
    rd(4'd0, 1'b1, d);  chk("R10 status before clear", 32'(d), 32'h40);
    rd(4'd0, 1'b0, d);  chk("R10 status cleared", 32'(d), 32'h00);
    wr(4'd0, 8'hFF);
    rd(4'd0, 1'b0, d);  chk("R1 status write ignored", 32'(d), 32'h00);

    for (int k = 0; k < NV; k++) do_xfer(VEC[k], k, 1'b0, vtag[k]);
    chk("R3 x_addr within size", 32'(addr_bad), 32'd0);
    chk("R11 grant waits seen", 32'(n_wait > 0), 32'd1);

    do_xfer({2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0400, 24'h000B00, 16'd3, 16'hFFFF},
            20, 1'b1, "R2 R12 deferred");
    pulse_trig();
    chk("R2 trigger while disarmed ignored", 32'(busy), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule